// File: doc/BRIEF.md
# Ripple Adder with Observation and Control Test Points

This block wraps a small piece of combinational logic, a parameterised ripple-carry adder, with test points that make its internal carry nets reachable from a single serial path. Every internal carry is a hard-to-observe node. Each one feeds an observation cell: a 2:1 multiplexer followed by a flip-flop. When scan enable is low, the cell samples its node. When scan enable is high, it takes the value of the cell before it. The cells therefore form an observation shift register whose last stage drives the one serial output pin.

A few chosen carry nets also get a control point. A multiplexer sits between the carry's source, which is the lower bit's carry output, and its destination, which is the next bit's carry input. With test mode low the source passes through unchanged. With test mode high a dedicated control flip-flop drives the destination instead. The control flip-flops sit at the head of the same serial path, so one serial input loads every control value. After enough shifts, the observation register unloads both the captured node values and the control values.

There is no stream traffic through this block. All pins are plain control and data pins, and there is no back-pressure. All flip-flops use the rising edge of one clock and a synchronous reset to 0.

Top module: `tpi_wrapper`

## Requirements
- R1: While `rst` is high at a rising edge, every control and observation flip-flop is cleared to 0, so `scan_out` reads 0 after reset and the whole chain then shifts out zeros.
- R2: With `test_mode` low, `{carry_out, sum}` equals `op_a + op_b + carry_in`, bit for bit, whatever the control flip-flops hold.
- R3: At a rising edge with `scan_en` low, observation stage j (j = 0 .. W-2) loads the carry out of adder bit j, which is the carry into bit j+1, taken before any control multiplexer.
- R4: At a rising edge with `scan_en` high, every stage of the serial path moves one place toward `scan_out`. `scan_out` is the last observation stage, so a bit entering at `scan_in` appears at `scan_out` after exactly NCTL + W - 1 shift edges.
- R5: The serial order is `scan_in`, then control flip-flop 0, 1, .. NCTL-1, then observation stage 0, 1, .. W-2. Loading control flip-flop k with value v therefore takes shifting the values for flip-flops NCTL-1 down to 0, in that order. The control flip-flops hold their value on every edge with `scan_en` low.
- R6: With `test_mode` high, the carry into adder bit p_k = floor((k+1)·W/(NCTL+1)) is taken from control flip-flop k (k = 0 .. NCTL-1). Every other bit receives the true carry of the bit below it, and bit 0 receives `carry_in`.
- R7: In test mode, an observation stage at a forced position still records the source-side carry (the majority of the lower bit's operands and its carry input), not the forced value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | 1 = shift the serial path, 0 = observation stages sample their nodes |
| test_mode | input | 1 | 1 = control flip-flops drive the forced carry nets |
| scan_in | input | 1 | Serial input into control flip-flop 0 |
| scan_out | output | 1 | Serial output from the last observation stage |
| op_a | input | W | Adder operand A |
| op_b | input | W | Adder operand B |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | W | Adder sum |
| carry_out | output | 1 | Carry out of bit W-1 |

## Verification
Operand pairs are chosen so that the carries either all stay low (zeros), ripple through every bit (all-ones plus one, complementary patterns with a carry in), or form mixed patterns. A stuck or misrouted tap therefore shows up as a wrong bit in the unloaded carry sequence. Each pattern is run with test mode both off and on, and with control values that either agree or disagree with the true carry. Forcing a carry that disagrees separates a working multiplexer from a bypassed one. The same forcing separates a tap on the source side from one on the destination side. The control values are unloaded after the captured bits, which shows that they held through the capture edge. A single-one pulse and an all-ones fill, followed by a reset, pin down the chain length and the reset value.

// File: rtl/tpi_pkg.sv
package tpi_pkg;

  // Carry position (the bit whose carry input is overridden) of control point k.
  function automatic int ctl_pos(input int k, input int width, input int nctl);
    return ((k + 1) * width) / (nctl + 1);
  endfunction

endpackage

// File: rtl/tpi_obs_cell.sv
module tpi_obs_cell (
  input  logic clk,
  input  logic rst,
  input  logic scan_en,
  input  logic node,
  input  logic shift_in,
  output logic q
);

  logic d;

  // Sample the node, or take the previous stage while shifting.
  assign d = scan_en ? shift_in : node;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

endmodule

// File: rtl/tpi_obs_chain.sv
module tpi_obs_chain #(
  parameter int NOBS = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scan_en,
  input  logic            chain_in,
  input  logic [NOBS-1:0] tap,
  output logic            scan_out
);

  logic [NOBS-1:0] obs_q;
  logic [NOBS-1:0] link;

  for (genvar j = 0; j < NOBS; j++) begin : g_stage
    if (j == 0) begin : g_head
      assign link[j] = chain_in;
    end else begin : g_body
      assign link[j] = obs_q[j-1];
    end

    tpi_obs_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .scan_en  (scan_en),
      .node     (tap[j]),
      .shift_in (link[j]),
      .q        (obs_q[j])
    );

    // R3: capture of the tapped node
    a_r3_capture : assert property (@(posedge clk) disable iff (rst)
      !scan_en |=> obs_q[j] == $past(tap[j]));
    // R4: one-place shift toward the output
    a_r4_shift_stage : assert property (@(posedge clk) disable iff (rst)
      scan_en |=> obs_q[j] == $past(link[j]));
  end

  assign scan_out = obs_q[NOBS-1];

endmodule

// File: rtl/tpi_ctl_chain.sv
module tpi_ctl_chain #(
  parameter int NCTL = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scan_en,
  input  logic            scan_in,
  output logic [NCTL-1:0] ctl_q,
  output logic            chain_out
);

  for (genvar k = 0; k < NCTL; k++) begin : g_ctl
    logic prev;
    if (k == 0) begin : g_head
      assign prev = scan_in;
    end else begin : g_body
      assign prev = ctl_q[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst)          ctl_q[k] <= 1'b0;
      else if (scan_en) ctl_q[k] <= prev;
    end
  end

  assign chain_out = ctl_q[NCTL-1];

  // R5: control values hold outside shifting
  a_r5_hold : assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> $stable(ctl_q));
  // R5: the serial input enters control flip-flop 0
  a_r5_entry : assert property (@(posedge clk) disable iff (rst)
    scan_en |=> ctl_q[0] == $past(scan_in));

endmodule

// File: rtl/tpi_adder_core.sv
module tpi_adder_core #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  input  logic [W-1:1] force_sel,
  input  logic [W-1:1] force_val,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry_src
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic c_use;
    logic c_out;
    if (i == 0) begin : g_lsb
      assign c_use = carry_in;
    end else begin : g_upper
      // Control point: source is the lower bit's carry, destination is this bit.
      assign c_use = force_sel[i] ? force_val[i] : g_bit[i-1].c_out;
    end
    assign c_out        = (op_a[i] & op_b[i]) | (op_a[i] & c_use) | (op_b[i] & c_use);
    assign sum[i]       = op_a[i] ^ op_b[i] ^ c_use;
    assign carry_src[i] = c_out;
  end

endmodule

// File: rtl/tpi_wrapper.sv
module tpi_wrapper #(
  parameter int W    = 8,
  parameter int NCTL = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         scan_en,
  input  logic         test_mode,
  input  logic         scan_in,
  output logic         scan_out,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         carry_out
);

  localparam int NOBS = W - 1;

  if (W < 2 || NCTL < 1 || NCTL >= W) begin : g_bad_params
    $error("tpi_wrapper: need W >= 2 and 1 <= NCTL < W");
  end

  logic [NCTL-1:0] ctl_q;
  logic            ctl_tail;
  logic [W-1:0]    carry_src;
  logic [W-1:1]    force_sel;
  logic [W-1:1]    force_val;

  tpi_ctl_chain #(.NCTL(NCTL)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .scan_en   (scan_en),
    .scan_in   (scan_in),
    .ctl_q     (ctl_q),
    .chain_out (ctl_tail)
  );

  always_comb begin
    force_sel = '0;
    force_val = '0;
    for (int k = 0; k < NCTL; k++) begin
      force_sel[tpi_pkg::ctl_pos(k, W, NCTL)] = test_mode;
      force_val[tpi_pkg::ctl_pos(k, W, NCTL)] = ctl_q[k];
    end
  end

  tpi_adder_core #(.W(W)) u_core (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .force_sel (force_sel),
    .force_val (force_val),
    .sum       (sum),
    .carry_src (carry_src)
  );

  assign carry_out = carry_src[W-1];

  tpi_obs_chain #(.NOBS(NOBS)) u_obs (
    .clk      (clk),
    .rst      (rst),
    .scan_en  (scan_en),
    .chain_in (ctl_tail),
    .tap      (carry_src[W-2:0]),
    .scan_out (scan_out)
  );

  // R2: transparent function outside test mode
  a_r2_functional : assert property (@(posedge clk) disable iff (rst)
    !test_mode |-> {carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in}));

  for (genvar k = 0; k < NCTL; k++) begin : g_force_chk
    localparam int P = tpi_pkg::ctl_pos(k, W, NCTL);
    // R6: the forced bit adds its control flip-flop as carry
    a_r6_forced : assert property (@(posedge clk) disable iff (rst)
      test_mode |-> sum[P] == (op_a[P] ^ op_b[P] ^ ctl_q[k]));
  end

endmodule

// File: tb/tpi_wrapper_tb.sv
`timescale 1ns/1ps
module tpi_wrapper_tb;

  localparam int W    = 8;
  localparam int NCTL = 3;
  localparam int NOBS = W - 1;
  localparam int LEN  = NCTL + NOBS;
  localparam int NVEC = 8;

  // {op_a, op_b, carry_in, test_mode, ctl[2:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 1'b0, 1'b0, 3'b000},
    {8'hFF, 8'h01, 1'b0, 1'b0, 3'b111},
    {8'hA5, 8'h5A, 1'b1, 1'b0, 3'b101},
    {8'h0F, 8'h01, 1'b0, 1'b1, 3'b000},
    {8'h00, 8'h00, 1'b0, 1'b1, 3'b111},
    {8'hFF, 8'h00, 1'b1, 1'b1, 3'b010},
    {8'h3C, 8'hC3, 1'b0, 1'b0, 3'b010},
    {8'h12, 8'h34, 1'b1, 1'b1, 3'b101}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         scan_en = 1'b0;
  logic         test_mode = 1'b0;
  logic         scan_in = 1'b0;
  logic         scan_out;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] sum;
  logic         carry_out;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  tpi_wrapper #(.W(W), .NCTL(NCTL)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .scan_en   (scan_en),
    .test_mode (test_mode),
    .scan_in   (scan_in),
    .scan_out  (scan_out),
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Reference adder with forced carries at floor((k+1)*W/(NCTL+1)).
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci,
                       input logic tm, input logic [NCTL-1:0] ctl,
                       output logic [W-1:0] s, output logic [W-1:0] csrc);
    logic c;
    c = ci;
    for (int i = 0; i < W; i++) begin
      for (int k = 0; k < NCTL; k++)
        if (tm && i == ((k + 1) * W) / (NCTL + 1)) c = ctl[k];
      s[i]    = a[i] ^ b[i] ^ c;
      csrc[i] = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
      c       = csrc[i];
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    logic [W-1:0]    exp_s;
    logic [W-1:0]    exp_c;
    logic [NCTL-1:0] ctl;
    logic            tm;

    // R1: reset dominates an active shift with a 1 on the serial input
    rst = 1'b1; scan_en = 1'b1; scan_in = 1'b1;
    repeat (3) step();
    rst = 1'b0; scan_in = 1'b0;
    @(negedge clk);
    check("R1 scan_out after reset", scan_out, 0);
    for (int j = 0; j < LEN; j++) begin
      @(negedge clk);
      check("R1 chain cleared", scan_out, 0);
      step();
    end

    // Vector table: load control values, capture, then unload everything
    for (int v = 0; v < NVEC; v++) begin
      ctl = VEC[v][2:0];
      tm  = VEC[v][3];
      scan_en = 1'b1;
      for (int k = NCTL - 1; k >= 0; k--) begin
        scan_in = ctl[k];   // R5: farthest control flip-flop first
        step();
      end
      scan_en   = 1'b0;
      scan_in   = 1'b0;
      op_a      = VEC[v][20:13];
      op_b      = VEC[v][12:5];
      carry_in  = VEC[v][4];
      test_mode = tm;
      model(op_a, op_b, carry_in, tm, ctl, exp_s, exp_c);
      @(negedge clk);
      if (!tm) check("R2 functional sum", {carry_out, sum}, {1'b0, op_a} + {1'b0, op_b} + carry_in);
      else     check("R6 forced-carry sum", {carry_out, sum}, {exp_c[W-1], exp_s});
      step();   // R3: capture edge
      scan_en = 1'b1;
      for (int j = 0; j < LEN; j++) begin
        @(negedge clk);
        if (j < NOBS) begin
          if (tm) check("R7 source-side tap", scan_out, exp_c[NOBS-1-j]);
          else    check("R3 captured carry", scan_out, exp_c[NOBS-1-j]);
        end else begin
          check("R5 control held and unloaded", scan_out, ctl[NCTL-1-(j-NOBS)]);
        end
        step();
      end
      scan_en = 1'b0;
      test_mode = 1'b0;
    end

    // R4: a single 1 reaches scan_out after exactly LEN shift edges
    scan_en = 1'b1; scan_in = 1'b0;
    repeat (LEN) step();
    scan_in = 1'b1;
    step();
    scan_in = 1'b0;
    for (int e = 1; e <= LEN + 2; e++) begin
      @(negedge clk);
      check("R4 shift latency", scan_out, (e == LEN) ? 1 : 0);
      step();
    end

    // R4 fill with ones, then R1 reset in the middle of operation
    scan_in = 1'b1;
    repeat (LEN) step();
    @(negedge clk);
    check("R4 ones fill", scan_out, 1);
    rst = 1'b1;
    step();
    rst = 1'b0; scan_in = 1'b0;
    for (int j = 0; j < LEN; j++) begin
      @(negedge clk);
      check("R1 mid-run reset clears", scan_out, 0);
      step();
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule